// File: doc/BRIEF.md
# Output Logic Macrocell Bank

This block is a row of output cells for a programmable logic array. Each cell takes the OR-sum produced by the array for its output, an output-enable product term and the value seen on its external pin. It returns three things: a pin data value, a pin enable, and a feedback bit that goes back into the array. The tristate pad is not part of the block. It is modelled as the separate `pin_out` and `pin_oe` signals, and the external pin level comes back on `pin_in`.

A 2-bit mode field per cell chooses between two paths:
- a registered path, or
- a combinational path.

The same field chooses active-high or active-low drive at the pin. The feedback source follows the mode:
- In registered mode the feedback carries the register state.
- In combinational mode the feedback carries the pin level. That is the driven value while the cell is enabled, and the external value while it is not, so a disabled pin acts as an input.

All cells share two terms:
- an asynchronous clear term, which acts at once without a clock;
- a synchronous preset term, which acts on the next rising clock edge.

A synchronous active-low reset clears every register and stands in for power-up.

Top module: `macrocell_bank`

## Requirements
- R1: Cell i reads its mode from `cfg_mode[2i+1:2i]`: 2'b00 registered active-low, 2'b01 registered active-high, 2'b10 combinational active-low, 2'b11 combinational active-high. Bit 1 selects combinational operation and bit 0 selects active-high drive.
- R2: While `areset_term` is high, every cell register is 0, with no clock edge needed.
- R3: A high `spreset_term` at a rising edge sets every register to 1 at that edge, overriding `sum_in`. It has no effect before the edge.
- R4: When `areset_term` and `spreset_term` are both high, registers stay at 0.
- R5: A low `rst_n` at a rising edge clears every register to 0. An active-low registered cell then drives `pin_out` high.
- R6: Otherwise each register loads its `sum_in` bit on every rising edge and holds between edges. In registered mode `fb_out` is the register value whatever the output enable.
- R7: In combinational mode `pin_out` follows `sum_in` (with polarity) in the same cycle. `fb_out` equals `pin_out` when `oe_term` is high and `pin_in` when it is low.
- R8: `pin_oe[i]` follows `oe_term[i]`, so a cell can be a fixed output, a fixed input or bidirectional.
- R9: Polarity is applied after the registered/combinational choice: active-low drives the inverse of the selected value, active-high drives it unchanged.
- R10: Each cell's mode acts only on that cell. The clear and preset terms act on all cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell registers |
| rst_n | input | 1 | Synchronous active-low reset (power-up clear) |
| cfg_mode | input | 2*CELLS | Per-cell mode field, two bits per cell |
| sum_in | input | CELLS | OR-sum from the logic array, one bit per cell |
| oe_term | input | CELLS | Output-enable product term per cell |
| areset_term | input | 1 | Shared asynchronous clear term |
| spreset_term | input | 1 | Shared synchronous preset term |
| pin_in | input | CELLS | Level seen on each external pin |
| pin_out | output | CELLS | Data value to drive on each pin |
| pin_oe | output | CELLS | Drive enable for each pin |
| fb_out | output | CELLS | Feedback into the logic array |

## Verification
The hardest situations to reach are the ones that happen between clock edges:
- the asynchronous clear acting in the middle of a cycle;
- a combinational cell with its enable low, where the feedback must track the external pin rather than the array result.

For the first, the bench raises the clear term at a falling edge and samples the feedback before the next rising edge. It also holds the clear across an edge together with the preset. For the second, the bench changes `pin_in`, `oe_term` and the mode with no clock edge in between, and checks the feedback mux as a purely combinational path. A final scenario programs a different mode into each of the first four cells, which exposes any crossing of per-cell fields.

// File: rtl/macrocell_pkg.sv
// Package: shared mode encoding for the output macrocell bank.
// Assumes a 2-bit field: bit 1 selects combinational, bit 0 selects active-high.
package macrocell_pkg;

    typedef enum logic [1:0] {
        MC_REG_LOW   = 2'b00,
        MC_REG_HIGH  = 2'b01,
        MC_COMB_LOW  = 2'b10,
        MC_COMB_HIGH = 2'b11
    } mc_mode_e;

    // True when the mode bypasses the register.
    function automatic logic mode_is_comb(input mc_mode_e m);
        return m[1];
    endfunction

    // True when the pin drives the selected value without inversion.
    function automatic logic mode_is_high(input mc_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/mc_state_reg.sv
// Module: state flop of one macrocell.
// Asynchronous clear wins over everything. A synchronous active-low reset
// models power-up. A synchronous preset wins over data.
module mc_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_async,
    input  logic preset_sync,
    input  logic d,
    output logic q
);

    // Purpose: hold the cell state with clear > reset > preset > data priority.
    always_ff @(posedge clk or posedge clear_async) begin
        if (clear_async) begin
            q <= 1'b0;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else if (preset_sync) begin
            q <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mc_out_path.sv
// Module: output path of one macrocell.
// Chooses the register or the combinational sum, then applies polarity.
// Assumes polarity is applied after the path choice.
module mc_out_path
    import macrocell_pkg::*;
(
    input  mc_mode_e mode,
    input  logic     q,
    input  logic     sum,
    output logic     pin_level
);

    logic selected;

    // Purpose: pick the data source, then invert it for active-low modes.
    always_comb begin
        selected  = mode_is_comb(mode) ? sum : q;
        pin_level = mode_is_high(mode) ? selected : ~selected;
    end

endmodule

// File: rtl/mc_feedback.sv
// Module: feedback select of one macrocell.
// Registered mode returns the true register state.
// Combinational mode returns the pin: the driven level when enabled,
// the external level when disabled.
module mc_feedback
    import macrocell_pkg::*;
(
    input  mc_mode_e mode,
    input  logic     q,
    input  logic     oe,
    input  logic     pin_level,
    input  logic     pin_ext,
    output logic     fb
);

    // Purpose: route the feedback source according to the mode and the enable.
    always_comb begin
        if (!mode_is_comb(mode)) begin
            fb = q;
        end else if (oe) begin
            fb = pin_level;
        end else begin
            fb = pin_ext;
        end
    end

endmodule

// File: rtl/macrocell_bank.sv
// Module: a bank of CELLS output macrocells sharing a clear and a preset term.
// Each cell has its own 2-bit mode field at cfg_mode[2i+1:2i].
// The pad is modelled as pin_out/pin_oe, with pin_in as the external level.
module macrocell_bank
    import macrocell_pkg::*;
#(
    parameter int CELLS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*CELLS-1:0] cfg_mode,
    input  logic [CELLS-1:0]   sum_in,
    input  logic [CELLS-1:0]   oe_term,
    input  logic               areset_term,
    input  logic               spreset_term,
    input  logic [CELLS-1:0]   pin_in,
    output logic [CELLS-1:0]   pin_out,
    output logic [CELLS-1:0]   pin_oe,
    output logic [CELLS-1:0]   fb_out
);

    localparam int MODE_W = 2;

    logic [CELLS-1:0] state_q;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        mc_mode_e cell_mode;

        // Purpose: decode this cell's mode field.
        always_comb cell_mode = mc_mode_e'(cfg_mode[MODE_W*i +: MODE_W]);

        mc_state_reg u_reg (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear_async (areset_term),
            .preset_sync (spreset_term),
            .d           (sum_in[i]),
            .q           (state_q[i])
        );

        mc_out_path u_out (
            .mode      (cell_mode),
            .q         (state_q[i]),
            .sum       (sum_in[i]),
            .pin_level (pin_out[i])
        );

        mc_feedback u_fb (
            .mode      (cell_mode),
            .q         (state_q[i]),
            .oe        (oe_term[i]),
            .pin_level (pin_out[i]),
            .pin_ext   (pin_in[i]),
            .fb        (fb_out[i])
        );
    end

    // Purpose: each pin driver is enabled by its own product term.
    always_comb pin_oe = oe_term;

endmodule

// File: rtl/macrocell_bank_checks.sv
// Module: property checker for macrocell_bank, attached by bind.
// Assumes the bench changes inputs away from the rising edge.
module macrocell_bank_checks #(
    parameter int CELLS = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*CELLS-1:0] cfg_mode,
    input logic [CELLS-1:0]   sum_in,
    input logic [CELLS-1:0]   oe_term,
    input logic               areset_term,
    input logic               spreset_term,
    input logic [CELLS-1:0]   pin_in,
    input logic [CELLS-1:0]   pin_out,
    input logic [CELLS-1:0]   fb_out
);

    logic [CELLS-1:0] regm;
    logic [CELLS-1:0] combm;
    logic [CELLS-1:0] highm;

    // Purpose: split the mode fields into per-cell masks (R1 encoding).
    always_comb begin
        for (int i = 0; i < CELLS; i++) begin
            combm[i] = cfg_mode[2*i+1];
            highm[i] = cfg_mode[2*i];
        end
        regm = ~combm;
    end

    assert_async_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        areset_term |-> ((fb_out & regm) == '0));

    assert_preset_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(spreset_term) && !$past(areset_term) &&
         !areset_term && $stable(cfg_mode))
        |-> ((fb_out & regm) == regm));

    assert_reg_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(spreset_term) && !$past(areset_term) &&
         !areset_term && $stable(cfg_mode))
        |-> ((fb_out & regm) == ($past(sum_in) & regm)));

    assert_comb_fb_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb_out ^ pin_in) & combm & ~oe_term) == '0);

    assert_comb_fb_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb_out ^ pin_out) & combm & oe_term) == '0);

    assert_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ fb_out) & regm) == (regm & ~highm));

endmodule

bind macrocell_bank macrocell_bank_checks #(.CELLS(CELLS)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .sum_in       (sum_in),
    .oe_term      (oe_term),
    .areset_term  (areset_term),
    .spreset_term (spreset_term),
    .pin_in       (pin_in),
    .pin_out      (pin_out),
    .fb_out       (fb_out)
);

// File: tb/macrocell_bank_test.sv
// Directed bench for macrocell_bank: one task per scenario, each checking itself.
module macrocell_bank_test;

    localparam int CELLS = 10;
    localparam logic [CELLS-1:0] ALL = '1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2*CELLS-1:0] cfg_mode = '0;
    logic [CELLS-1:0]   sum_in = '0;
    logic [CELLS-1:0]   oe_term = '0;
    logic               areset_term = 1'b0;
    logic               spreset_term = 1'b0;
    logic [CELLS-1:0]   pin_in = '0;
    logic [CELLS-1:0]   pin_out;
    logic [CELLS-1:0]   pin_oe;
    logic [CELLS-1:0]   fb_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    macrocell_bank #(.CELLS(CELLS)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .sum_in       (sum_in),
        .oe_term      (oe_term),
        .areset_term  (areset_term),
        .spreset_term (spreset_term),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .fb_out       (fb_out)
    );

    task automatic check(input string req, input logic [CELLS-1:0] act,
                         input logic [CELLS-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2*CELLS-1:0] all_mode(input logic [1:0] m);
        return {CELLS{m}};
    endfunction

    // Step over one rising edge and settle just after it.
    task automatic edge_settle();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cfg_mode = all_mode(2'b00);
        sum_in = ALL;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        sum_in = '0;
        #2;
        check("R5 reset clears register", fb_out, '0);
        check("R5 active-low drives high", pin_out, ALL);
        cfg_mode = all_mode(2'b01);
        #2;
        check("R9 active-high shows zero", pin_out, '0);
    endtask

    task automatic t_registered();
        @(negedge clk);
        cfg_mode = all_mode(2'b01);
        oe_term = '0;
        sum_in = 10'h2A5;
        edge_settle();
        check("R6 register load, oe low", fb_out, 10'h2A5);
        check("R1 reg active-high pin", pin_out, 10'h2A5);
        @(negedge clk);
        sum_in = 10'h15A;
        #2;
        check("R6 holds between edges", fb_out, 10'h2A5);
        edge_settle();
        check("R6 second load", fb_out, 10'h15A);
        cfg_mode = all_mode(2'b00);
        #2;
        check("R9 reg active-low inverts", pin_out, ~10'h15A);
        check("R6 feedback not inverted", fb_out, 10'h15A);
    endtask

    task automatic t_comb();
        @(negedge clk);
        cfg_mode = all_mode(2'b11);
        oe_term = ALL;
        sum_in = 10'h0F3;
        #2;
        check("R7 comb high pin", pin_out, 10'h0F3);
        check("R7 comb fb enabled", fb_out, 10'h0F3);
        cfg_mode = all_mode(2'b10);
        #2;
        check("R9 comb low pin", pin_out, ~10'h0F3);
        check("R7 comb fb follows pin", fb_out, ~10'h0F3);
        oe_term = '0;
        pin_in = 10'h3C1;
        #2;
        check("R7 disabled fb is pin_in", fb_out, 10'h3C1);
        check("R8 enables low", pin_oe, '0);
        oe_term = 10'h155;
        #2;
        check("R8 enables follow term", pin_oe, 10'h155);
        check("R7 mixed enables", fb_out,
              (~10'h0F3 & 10'h155) | (10'h3C1 & ~10'h155));
    endtask

    task automatic t_async();
        @(negedge clk);
        cfg_mode = all_mode(2'b01);
        sum_in = ALL;
        edge_settle();
        check("R6 load ones", fb_out, ALL);
        @(negedge clk);
        areset_term = 1'b1;
        #2;
        check("R2 clear without edge", fb_out, '0);
        check("R2 pin follows clear", pin_out, '0);
        edge_settle();
        check("R2 clear holds over edge", fb_out, '0);
        @(negedge clk);
        areset_term = 1'b0;
        edge_settle();
        check("R6 loads after clear", fb_out, ALL);
    endtask

    task automatic t_preset();
        @(negedge clk);
        sum_in = '0;
        edge_settle();
        @(negedge clk);
        spreset_term = 1'b1;
        #2;
        check("R3 no effect before edge", fb_out, '0);
        edge_settle();
        check("R3 preset over sum", fb_out, ALL);
        @(negedge clk);
        spreset_term = 1'b0;
        edge_settle();
        check("R6 data after preset", fb_out, '0);
    endtask

    task automatic t_both();
        @(negedge clk);
        sum_in = ALL;
        areset_term = 1'b1;
        spreset_term = 1'b1;
        edge_settle();
        check("R4 clear beats preset", fb_out, '0);
        @(negedge clk);
        areset_term = 1'b0;
        sum_in = '0;
        edge_settle();
        check("R3 preset after clear released", fb_out, ALL);
        @(negedge clk);
        spreset_term = 1'b0;
    endtask

    task automatic t_mixed();
        @(negedge clk);
        cfg_mode = all_mode(2'b01);
        cfg_mode[7:0] = {2'b11, 2'b10, 2'b01, 2'b00};
        oe_term = ALL;
        sum_in = ALL;
        edge_settle();
        @(negedge clk);
        sum_in = '0;
        #2;
        check("R10 per-cell modes pin", pin_out, 10'h3F6);
        check("R1 per-cell modes fb", fb_out, 10'h3F7);
    endtask

    initial begin
        t_reset();
        t_registered();
        t_comb();
        t_async();
        t_preset();
        t_both();
        t_mixed();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule